// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each cycle it can take two 16-bit operands, x and y, and an operation code. It forms a product in a 17x17 multiplier and combines that product with one of two 40-bit accumulators, A or B, in a 41-bit adder/subtracter. The engine also offers accumulator-to-accumulator operations that use no operand data. The selected accumulator is written on the rising clock edge. The other accumulator keeps its value.

Mode inputs set how the operands and the result are treated:
- integer or fractional product (a fractional product is doubled);
- signed or unsigned operands;
- independent saturation enables for A and for B;
- a limit select, which clamps either to the 32-bit range or to the full 40-bit range.

A combinational store path rounds the selected accumulator to a 16-bit word taken from bits 31:16. It uses conventional or convergent rounding, with optional clamping to the 16-bit range.

Top module: `dual_mac_engine`

## Requirements
- R1: After reset both accumulators read zero and all four status flags are low.
- R2: With `en` high, codes 1 CLR (0), 2 ED ((x-y)^2), 6 MPY (x*y), 7 MPY-square (x*x) and 8 MPY-negate (-(x*y)) write their result into the accumulator picked by `acc_sel` (0 = A, 1 = B) at the next rising edge.
- R3: Codes 3 EDAC (+(x-y)^2), 4 MAC (+x*y), 5 MAC-square (+x*x) and 9 MSC (-x*y) add their term to, or subtract it from, the selected accumulator.
- R4: With `signed_mode` high the operands are sign-extended to 17 bits; with it low they are zero-extended. With `frac_mode` high every product is doubled before it is combined.
- R5: Code 10 writes A+B, code 11 writes selected minus other, and code 12 writes the negated selected accumulator, each into the selected accumulator.
- R6: `en` low, code 0, and codes 13 to 15 leave both accumulators and the flags unchanged. An operation never changes the unselected accumulator.
- R7: With the selected accumulator's saturation enable high and `sat_ext` low, a result is clamped to the range -2^31 to 2^31-1.
- R8: With `sat_ext` high the clamp is -2^39 to 2^39-1. With saturation disabled the result wraps modulo 2^40.
- R9: On each write, the accumulator's overflow flag records whether the exact result left the 40-bit range, and its saturation flag records whether clamping changed the result. Both flags hold between writes.
- R10: `wr_data` is bits 31:16 of the selected accumulator after adding 2^15 (conventional rounding, `rnd_conv` low).
- R11: With `rnd_conv` high, when bits 15:0 are exactly 0x8000 the value rounds to the even result. Other values round as in R10.
- R12: With `sat_wr_en` high, a rounded value above 32767 gives 0x7FFF and one below -32768 gives 0x8000. With it low, the low 16 bits of the rounded value are output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Perform the operation this cycle |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | Target and store-source accumulator, 0 = A |
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| frac_mode | input | 1 | Double the product |
| signed_mode | input | 1 | Sign-extend operands |
| rnd_conv | input | 1 | Convergent rounding on the store path |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_wr_en | input | 1 | Saturation of the store word |
| sat_ext | input | 1 | Clamp to 40-bit instead of 32-bit range |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| wr_data | output | 16 | Rounded store word |
| ovf_a | output | 1 | A's last write left the 40-bit range |
| ovf_b | output | 1 | B's last write left the 40-bit range |
| sat_a | output | 1 | A's last write was clamped |
| sat_b | output | 1 | B's last write was clamped |

## Verification
The bench targets the square of the most negative fractional operand, which equals exactly 2^31. A clamp that is off by one lets this value through, or clamps the exact negative limit and raises a false saturation flag. Unsigned 0xFFFF operands and an unsigned difference x-y near -65535 are also tested. A design that sign-extends these gets 1 instead of 0xFFFE0001. The store path is checked with exact halves of both parities and of both signs, where convergent and conventional rounding disagree. Repeated A+B doubling drives the value into the 40-bit extended limit and then past it with saturation off. This exposes a design that wraps where it should clamp, or that reports overflow incorrectly.

// File: rtl/dual_mac_engine.sv
module dual_mac_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [3:0]  op,
  input  logic        acc_sel,
  input  logic [15:0] x,
  input  logic [15:0] y,
  input  logic        frac_mode,
  input  logic        signed_mode,
  input  logic        rnd_conv,
  input  logic        sat_en_a,
  input  logic        sat_en_b,
  input  logic        sat_wr_en,
  input  logic        sat_ext,
  output logic [39:0] acc_a,
  output logic [39:0] acc_b,
  output logic [15:0] wr_data,
  output logic        ovf_a,
  output logic        ovf_b,
  output logic        sat_a,
  output logic        sat_b
);
  localparam logic [3:0] OP_HOLD = 4'd0, OP_CLR = 4'd1, OP_ED = 4'd2, OP_EDAC = 4'd3,
                         OP_MAC = 4'd4, OP_MACSQ = 4'd5, OP_MPY = 4'd6, OP_MPYSQ = 4'd7,
                         OP_MPYN = 4'd8, OP_MSC = 4'd9, OP_ADD = 4'd10, OP_SUB = 4'd11,
                         OP_NEG = 4'd12;

  logic signed [16:0] xe, ye, diff, ma, mb;
  logic signed [33:0] prod;
  logic signed [40:0] term, cur, oth, exact, hi, lo;
  logic [39:0] result;
  logic writes, sat_on, clamp_hi, clamp_lo;
  logic is_ed, is_sq;

  assign xe   = signed_mode ? {x[15], x} : {1'b0, x};
  assign ye   = signed_mode ? {y[15], y} : {1'b0, y};
  assign diff = xe - ye;
  assign is_ed = (op == OP_ED) || (op == OP_EDAC);
  assign is_sq = (op == OP_MACSQ) || (op == OP_MPYSQ);
  assign ma   = is_ed ? diff : xe;
  assign mb   = is_ed ? diff : (is_sq ? xe : ye);
  assign prod = 34'(ma) * 34'(mb);
  assign term = frac_mode ? (41'(prod) <<< 1) : 41'(prod);

  assign cur = acc_sel ? 41'($signed(acc_b)) : 41'($signed(acc_a));
  assign oth = acc_sel ? 41'($signed(acc_a)) : 41'($signed(acc_b));

  always_comb begin
    writes = en;
    exact  = cur;
    case (op)
      OP_CLR:                    exact = '0;
      OP_ED, OP_MPY, OP_MPYSQ:   exact = term;
      OP_EDAC, OP_MAC, OP_MACSQ: exact = cur + term;
      OP_MPYN:                   exact = -term;
      OP_MSC:                    exact = cur - term;
      OP_ADD:                    exact = cur + oth;
      OP_SUB:                    exact = cur - oth;
      OP_NEG:                    exact = -cur;
      default:                   writes = 1'b0;
    endcase
  end

  assign hi       = sat_ext ? 41'sh0_7F_FFFF_FFFF : 41'sh0_00_7FFF_FFFF;
  assign lo       = ~hi;
  assign sat_on   = acc_sel ? sat_en_b : sat_en_a;
  assign clamp_hi = sat_on && (exact > hi);
  assign clamp_lo = sat_on && (exact < lo);
  assign result   = clamp_hi ? hi[39:0] : (clamp_lo ? lo[39:0] : exact[39:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0; acc_b <= '0;
      ovf_a <= 1'b0; ovf_b <= 1'b0; sat_a <= 1'b0; sat_b <= 1'b0;
    end else if (writes) begin
      if (acc_sel) begin
        acc_b <= result; ovf_b <= exact[40] ^ exact[39]; sat_b <= clamp_hi | clamp_lo;
      end else begin
        acc_a <= result; ovf_a <= exact[40] ^ exact[39]; sat_a <= clamp_hi | clamp_lo;
      end
    end
  end

  logic [39:0] src;
  logic        half_tie;
  logic signed [24:0] rq;

  assign src      = acc_sel ? acc_b : acc_a;
  assign half_tie = (src[15:0] == 16'h8000) && !src[16];
  assign rq       = 25'((41'($signed(src)) + ((rnd_conv && half_tie) ? 41'sd0 : 41'sd32768)) >>> 16);

  always_comb begin
    if (sat_wr_en && rq > 25'sd32767)       wr_data = 16'h7FFF;
    else if (sat_wr_en && rq < -25'sd32768) wr_data = 16'h8000;
    else                                    wr_data = rq[15:0];
  end

  always_comb begin
    if (sat_wr_en && rq > 25'sd32767)
      assert_wr_clamp_hi_R12: assert (wr_data == 16'h7FFF);
  end

  assert_unsel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_sel) |=> acc_a == $past(acc_a));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc_a == $past(acc_a)) && (acc_b == $past(acc_b)));

  assert_clr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_CLR && !acc_sel) |=> acc_a == 40'd0);

  assert_norm_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (writes && !acc_sel && sat_en_a && !sat_ext) |=>
      ($signed(acc_a) <= 40'sh00_7FFF_FFFF) && ($signed(acc_a) >= -40'sh00_8000_0000));

  assert_no_sat_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (writes && acc_sel && !sat_en_b) |=> !sat_b);

  assert_hold_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_HOLD) |=> $stable(acc_a) && $stable(acc_b) && $stable(sat_a) && $stable(sat_b));
endmodule

// File: tb/tb_dual_mac_engine.sv
`timescale 1ns/1ps
module tb_dual_mac_engine;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, acc_sel = 1'b0;
  logic [3:0] op = 4'd0;
  logic [15:0] x = '0, y = '0;
  logic frac_mode = 0, signed_mode = 1, rnd_conv = 0;
  logic sat_en_a = 0, sat_en_b = 0, sat_wr_en = 0, sat_ext = 0;
  logic [39:0] acc_a, acc_b;
  logic [15:0] wr_data;
  logic ovf_a, ovf_b, sat_a, sat_b;

  dual_mac_engine dut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_sel(acc_sel),
    .x(x), .y(y), .frac_mode(frac_mode), .signed_mode(signed_mode), .rnd_conv(rnd_conv),
    .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_wr_en(sat_wr_en), .sat_ext(sat_ext),
    .acc_a(acc_a), .acc_b(acc_b), .wr_data(wr_data),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b));

  localparam logic [3:0] HOLD = 0, CLR = 1, ED = 2, EDAC = 3, MAC = 4, MACSQ = 5, MPY = 6,
                         MPYSQ = 7, MPYN = 8, MSC = 9, ADD = 10, SUB = 11, NEG = 12;

  int errs = 0, checks = 0;
  longint ma = 0, mb = 0;
  bit fova = 0, fsa = 0, fovb = 0, fsb = 0;

  function automatic longint s40(logic [39:0] v); return longint'($signed(v)); endfunction
  function automatic longint wrap40(longint e); return (e <<< 24) >>> 24; endfunction
  function automatic longint opnd(logic [15:0] v);
    return signed_mode ? longint'($signed(v)) : longint'(v);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " acc_a"}, s40(acc_a), ma);
    chk({tag, " acc_b"}, s40(acc_b), mb);
    chk({tag, " flags R9"}, {ovf_a, sat_a, ovf_b, sat_b}, {fova, fsa, fovb, fsb});
  endtask

  task automatic step(logic [3:0] opc, logic sel, logic [15:0] xv, logic [15:0] yv, string tag);
    longint xe, ye, p, e, cur, lim, r;
    bit w, son, ov, st;
    xe = opnd(xv); ye = opnd(yv);
    cur = sel ? mb : ma;
    case (opc)
      MPY, MAC, MSC, MPYN: p = xe * ye;
      MPYSQ, MACSQ:        p = xe * xe;
      ED, EDAC:            p = (xe - ye) * (xe - ye);
      default:             p = 0;
    endcase
    if (frac_mode) p = p * 2;
    w = 1;
    case (opc)
      CLR: e = 0;
      ED, MPY, MPYSQ: e = p;
      EDAC, MAC, MACSQ: e = cur + p;
      MPYN: e = -p;
      MSC: e = cur - p;
      ADD: e = ma + mb;
      SUB: e = cur - (sel ? ma : mb);
      NEG: e = -cur;
      default: begin w = 0; e = 0; end
    endcase
    if (w) begin
      lim = sat_ext ? 64'sh7F_FFFF_FFFF : 64'sh7FFF_FFFF;
      son = sel ? sat_en_b : sat_en_a;
      ov  = (e > 64'sh7F_FFFF_FFFF) || (e < -64'sh80_0000_0000);
      st  = 0;
      if (son && e > lim) begin r = lim; st = 1; end
      else if (son && e < -lim - 1) begin r = -lim - 1; st = 1; end
      else r = wrap40(e);
      if (sel) begin mb = r; fovb = ov; fsb = st; end
      else begin ma = r; fova = ov; fsa = st; end
    end
    @(negedge clk);
    en = 1; op = opc; acc_sel = sel; x = xv; y = yv;
    @(negedge clk);
    en = 0;
    chk_state(tag);
  endtask

  function automatic longint exp_wr(longint v);
    longint q;
    if (rnd_conv && ((v & 64'hFFFF) == 64'h8000)) q = (v >>> 16) + ((v >>> 16) & 1);
    else q = (v + 32768) >>> 16;
    if (sat_wr_en && q > 32767) q = 32767;
    if (sat_wr_en && q < -32768) q = -32768;
    return q & 64'hFFFF;
  endfunction

  task automatic chk_wr(logic sel, string tag);
    @(negedge clk); acc_sel = sel; #1;
    chk(tag, longint'(wr_data), exp_wr(sel ? mb : ma));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1 reset");
    chk("R1 reset wr_data", longint'(wr_data), 0);
  endtask

  task automatic t_int_ops;
    frac_mode = 0; signed_mode = 1;
    step(MPY, 0, 16'd3, -16'sd4, "R2 MPY");
    chk("R2 MPY literal", s40(acc_a), -12);
    step(MAC, 0, 16'd5, 16'd6, "R3 MAC");
    step(MSC, 0, 16'd2, 16'd2, "R3 MSC");
    chk("R3 MSC literal", s40(acc_a), 14);
    step(MPYN, 1, 16'd7, 16'd3, "R2 MPYN");
    chk("R2 MPYN literal", s40(acc_b), -21);
    step(ED, 0, 16'd10, 16'd3, "R2 ED");
    step(EDAC, 0, 16'd1, 16'd4, "R3 EDAC");
    chk("R3 EDAC literal", s40(acc_a), 58);
    step(MPYSQ, 1, -16'sd3, 16'd99, "R2 MPYSQ");
    step(MACSQ, 1, 16'd4, 16'd99, "R3 MACSQ");
    chk("R3 MACSQ literal", s40(acc_b), 25);
    step(CLR, 1, 16'd0, 16'd0, "R2 CLR");
  endtask

  task automatic t_ext;
    signed_mode = 0;
    step(MPY, 0, 16'hFFFF, 16'hFFFF, "R4 unsigned MPY");
    chk("R4 unsigned literal", s40(acc_a), 64'hFFFE0001);
    step(ED, 1, 16'h0000, 16'hFFFF, "R4 unsigned ED");
    signed_mode = 1;
    step(MPY, 0, 16'hFFFF, 16'hFFFF, "R4 signed MPY");
    chk("R4 signed literal", s40(acc_a), 1);
    frac_mode = 1;
    step(MPY, 0, 16'h4000, 16'h4000, "R4 frac MPY");
    chk("R4 frac literal", s40(acc_a), 64'h20000000);
    frac_mode = 0;
  endtask

  task automatic t_accacc;
    step(MPY, 0, 16'd10, 16'd10, "R5 load A");
    step(MPY, 1, -16'sd7, 16'd3, "R5 load B");
    step(ADD, 1, 16'd0, 16'd0, "R5 ADD");
    chk("R5 ADD literal", s40(acc_b), 79);
    step(SUB, 0, 16'd0, 16'd0, "R5 SUB");
    chk("R5 SUB literal", s40(acc_a), 21);
    step(NEG, 1, 16'd0, 16'd0, "R5 NEG");
  endtask

  task automatic t_hold;
    @(negedge clk); en = 0; op = MAC; x = 16'd5; y = 16'd5;
    repeat (2) @(negedge clk);
    chk_state("R6 en low");
    step(HOLD, 0, 16'd9, 16'd9, "R6 code 0");
    step(4'd15, 1, 16'd9, 16'd9, "R6 code 15");
    step(MAC, 1, 16'd9, 16'd9, "R6 unselected A");
  endtask

  task automatic t_sat_norm;
    frac_mode = 1; sat_ext = 0; sat_en_a = 1; sat_en_b = 0;
    step(MPY, 0, 16'h8000, 16'h8000, "R7 clamp A");
    chk("R7 clamp literal", s40(acc_a), 64'h7FFFFFFF);
    step(MPY, 1, 16'h8000, 16'h8000, "R7 B unsaturated");
    chk("R7 B literal", s40(acc_b), 64'h80000000);
    step(MPYN, 0, 16'h8000, 16'h8000, "R7 exact low limit");
    step(MSC, 0, 16'h0001, 16'h0001, "R7 clamp low");
    chk("R7 low literal", s40(acc_a), -64'sh80000000);
    frac_mode = 0;
  endtask

  task automatic t_sat_ext;
    frac_mode = 1; sat_ext = 1; sat_en_a = 1; sat_en_b = 1;
    step(MPY, 0, 16'h8000, 16'h8000, "R8 seed A");
    step(MPY, 1, 16'h8000, 16'h8000, "R8 seed B");
    for (int i = 0; i < 8; i++) begin
      step(ADD, 0, 16'd0, 16'd0, "R8 grow A");
      step(ADD, 1, 16'd0, 16'd0, "R8 grow B");
    end
    chk("R8 extended limit", s40(acc_b), 64'sh7F_FFFF_FFFF);
    sat_en_a = 0;
    step(ADD, 0, 16'd0, 16'd0, "R8 wrap with sat off");
    step(NEG, 1, 16'd0, 16'd0, "R8 negate limit");
    frac_mode = 0; sat_ext = 0; sat_en_b = 0;
  endtask

  task automatic t_round;
    frac_mode = 0; signed_mode = 1; sat_en_a = 0;
    step(MPY, 0, 16'd384, 16'd256, "R10 load 1.5");
    rnd_conv = 0; chk_wr(0, "R10 conv 1.5");
    rnd_conv = 1; chk_wr(0, "R11 conv'g 1.5");
    step(MPY, 0, 16'd320, 16'd512, "R11 load 2.5");
    rnd_conv = 0; chk_wr(0, "R10 conv 2.5");
    chk("R10 conv 2.5 literal", longint'(wr_data), 3);
    rnd_conv = 1; chk_wr(0, "R11 conv'g 2.5");
    chk("R11 conv'g 2.5 literal", longint'(wr_data), 2);
    step(MPY, 1, -16'sd384, 16'd256, "R11 load -1.5");
    rnd_conv = 0; chk_wr(1, "R10 conv -1.5");
    chk("R10 conv -1.5 literal", longint'(wr_data), 64'hFFFF);
    rnd_conv = 1; chk_wr(1, "R11 conv'g -1.5");
    chk("R11 conv'g -1.5 literal", longint'(wr_data), 64'hFFFE);
    step(MPY, 1, 16'd321, 16'd511, "R11 load above half");
    chk_wr(1, "R11 conv'g above half");
    rnd_conv = 0;
  endtask

  task automatic t_wrsat;
    frac_mode = 1;
    step(MPY, 0, 16'h8000, 16'h8000, "R12 load 2^31");
    sat_wr_en = 1; chk_wr(0, "R12 high clamp");
    chk("R12 high literal", longint'(wr_data), 64'h7FFF);
    sat_wr_en = 0; chk_wr(0, "R12 no clamp");
    chk("R12 no clamp literal", longint'(wr_data), 64'h8000);
    signed_mode = 0;
    step(MPYN, 1, 16'hFFFF, 16'hFFFF, "R12 load large negative");
    sat_wr_en = 1; chk_wr(1, "R12 low clamp");
    chk("R12 low literal", longint'(wr_data), 64'h8000);
    sat_wr_en = 0; chk_wr(1, "R12 low no clamp");
    signed_mode = 1; frac_mode = 0;
  endtask

  initial begin
    fork
      begin
        t_reset; t_int_ops; t_ext; t_accacc; t_hold;
        t_sat_norm; t_sat_ext; t_round; t_wrsat;
      end
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule